// File: doc/BRIEF.md
# DMA Window Address Translator

This block sits between an I/O bus and system memory. It turns the addresses that bus masters use for DMA into system memory addresses. Software programs a small set of windows. Each window has a base, a size mask and a translated base. A window maps its region either straight onto a block of system memory, or through a table of page entries that the block reads from memory, one 8 KiB page per entry.

Requests carrying 32-bit addresses are matched against the windows in a fixed priority order. An optional hole just below 1 MiB blocks all matching. Requests carrying wider, dual-cycle addresses take one of two paths. The first is a large fixed direct window that maps its whole range onto the bottom of system memory. The second is a page-table path owned by the last window, enabled by a per-window dual-cycle bit. The block handles one translation at a time. Page entries are fetched through a single-beat 64-bit read port with a valid/ready request and a valid-only return beat.

Top module: `dmawin_xlate`

## Requirements
- R1: After reset, every window and control register reads as zero, except the last window's base, which reads 0x2. `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0.
- R2: CSR map, with accesses 64 bits wide. Window i has its base at 0x000+0x40·i, its mask at 0x100+0x40·i and its translated base at 0x200+0x40·i. A write keeps these bits of the written data:
  - bases of windows 0–2: 0xFFF0_0003;
  - all masks: 0xFFF0_0000;
  - all translated bases: 0x7_FFFF_FC00;
  - base of window 3: bits 31:20, bit 0 and the dual-cycle enable bit (bit 43 by default), and it always reads with bit 1 set.
- R3: The control register at 0x300 changes only the bits in 0x1C_FF0F_C7FF on a write. Bit 5 enables the hole and bit 6 enables the large direct window.
- R4: A window is enabled by base bit 0. With ext = mask | 0xFFFFF, it hits when (addr & ~ext) == (base & 0xFFF0_0000). When base bit 1 is clear, a hit gives (tba & ~ext) | (addr & ext). A fetch-free result comes out as a one-cycle `rsp_valid` pulse in the cycle after acceptance.
- R5: When base bit 1 is set, a hit reads the page entry at (tba & ~(mask>>10)) | ((addr & (mask|0xFE000))>>10). The result is ((pte & 0x3FFFFE)<<12) | (addr & 0x1FFF), delivered in the cycle after the read data returns.
- R6: A page entry whose bit 0 is clear gives a failed response.
- R7: For an address no larger than 0xFFFF_FFFF, windows 0, 1 and 2 are tried in that order, and the first hit wins.
- R8: Window 3 takes part in 32-bit matching only while its dual-cycle enable bit is clear.
- R9: With control bit 5 set, a 32-bit address in 0x80000–0xFFFFF fails even when a window would hit.
- R10: With control bit 6 set, an address in [0x100_0000_0000, 0x200_0000_0000) translates to addr & 0x7_FFFF_FFFF.
- R11: An address in [0x800_0000_0000, 0xFFF_FFFF_FFFF] uses window 3's page table when that window's enable bit and dual-cycle bit are both set. The entry address is (tba & 0x7_FFC0_0000) | ((addr & 0xFFFF_E000)>>10), and the result is formed as in R5.
- R12: An address that matches no path fails, and a failed response carries `rsp_addr` = 0. `req_ready` stays low from acceptance until the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | CAW (12) | CSR byte offset |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | Combinational read data of the addressed CSR |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr | input | 64 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_addr | output | 64 | Translated system address, zero on failure |
| mem_rd_valid | output | 1 | Page-entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 64 | Page-entry address |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_data | input | 64 | Page entry returned by memory |

## Verification
A request is accepted on the clock edge where `req_valid` and `req_ready` are both high. Direct, large-window and failed translations raise `rsp_valid` exactly one cycle later, for one cycle. A page-table translation raises `mem_rd_valid` in the cycle after acceptance and holds it until `mem_rd_ready`; the response follows one cycle after the `mem_rsp_valid` beat. The bench drives and samples on the falling edge and checks each of these outputs in the single cycle where it is due. It also checks the cycle before and the cycle after, to confirm that the pulse does not come early or stay high and that `req_ready` is low while a translation is in flight.

// File: rtl/dmawin_pkg.sv
package dmawin_pkg;

  localparam int XW = 64;

  localparam logic [XW-1:0] BASE_FIELD    = 64'h0000_0000_FFF0_0000;
  localparam logic [XW-1:0] BASE_KEEP     = 64'h0000_0000_FFF0_0003;
  localparam logic [XW-1:0] MASK_KEEP     = 64'h0000_0000_FFF0_0000;
  localparam logic [XW-1:0] TBA_KEEP      = 64'h0000_0007_FFFF_FC00;
  localparam logic [XW-1:0] CTL_KEEP      = 64'h0000_001C_FF0F_C7FF;
  localparam logic [XW-1:0] LOW_SPAN      = 64'h0000_0000_000F_FFFF;
  localparam logic [XW-1:0] SG_IDX_BITS   = 64'h0000_0000_000F_E000;
  localparam logic [XW-1:0] BIG_WIN_MASK  = 64'h0000_0007_FFFF_FFFF;
  localparam logic [XW-1:0] DAC_TBA_KEEP  = 64'h0000_0007_FFC0_0000;
  localparam logic [XW-1:0] DAC_IDX_BITS  = 64'h0000_0000_FFFF_E000;
  localparam logic [XW-1:0] PTE_PFN_BITS  = 64'h0000_0000_003F_FFFE;
  localparam int            PTE_SHIFT     = 10;
  localparam int            PAGE_BITS     = 13;
  localparam int            PFN_SHIFT     = 12;
  localparam int            HOLE_EN_BIT   = 5;
  localparam int            BIGWIN_EN_BIT = 6;

  typedef struct packed {
    logic [XW-1:0] base;
    logic [XW-1:0] mask;
    logic [XW-1:0] tba;
  } win_regs_t;

  typedef enum logic [1:0] {
    XL_FAIL   = 2'd0,
    XL_DIRECT = 2'd1,
    XL_SG     = 2'd2
  } xl_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } xl_state_e;

endpackage

// File: rtl/dmawin_regs.sv
module dmawin_regs
  import dmawin_pkg::*;
#(
  parameter int NWIN    = 4,
  parameter int DAC_BIT = 43,
  parameter int CAW     = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       csr_we,
  input  logic [CAW-1:0]             csr_addr,
  input  logic [XW-1:0]              csr_wdata,
  output logic [XW-1:0]              csr_rdata,
  output win_regs_t [NWIN-1:0]       win_o,
  output logic [XW-1:0]              ctl_o
);

  localparam int            LASTW   = NWIN - 1;
  localparam logic [XW-1:0] W3_KEEP = (BASE_KEEP & ~64'h2) | (64'h1 << DAC_BIT);

  logic       aligned;
  logic [1:0] grp;
  logic [1:0] idx;

  assign grp     = csr_addr[9:8];
  assign idx     = csr_addr[7:6];
  assign aligned = (csr_addr[5:0] == 6'd0) && (csr_addr[CAW-1:10] == '0);

  win_regs_t [NWIN-1:0] win_q;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam logic [XW-1:0] KEEP  = (i == LASTW) ? W3_KEEP : BASE_KEEP;
    localparam logic [XW-1:0] FORCE = (i == LASTW) ? 64'h2 : 64'h0;

    win_regs_t q, d;
    logic      sel, hit_b, hit_m, hit_t, en;

    assign sel   = csr_we && aligned && (idx == 2'(i));
    assign hit_b = sel && (grp == 2'd0);
    assign hit_m = sel && (grp == 2'd1);
    assign hit_t = sel && (grp == 2'd2);
    assign en    = hit_b || hit_m || hit_t;

    always_comb begin
      d = q;
      if (hit_b) d.base = (csr_wdata & KEEP) | FORCE;
      if (hit_m) d.mask = csr_wdata & MASK_KEEP;
      if (hit_t) d.tba  = csr_wdata & TBA_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q.base <= FORCE;
        q.mask <= '0;
        q.tba  <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign win_q[i] = q;
  end

  logic [XW-1:0] ctl_q, ctl_d;
  logic          ctl_en;

  assign ctl_en = csr_we && aligned && (grp == 2'd3) && (idx == 2'd0);

  always_comb begin
    ctl_d = (ctl_q & ~CTL_KEEP) | (csr_wdata & CTL_KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (aligned) begin
      unique case (grp)
        2'd0: if (32'(idx) < NWIN) csr_rdata = win_q[idx].base;
        2'd1: if (32'(idx) < NWIN) csr_rdata = win_q[idx].mask;
        2'd2: if (32'(idx) < NWIN) csr_rdata = win_q[idx].tba;
        default: if (idx == 2'd0) csr_rdata = ctl_q;
      endcase
    end
  end

  assign win_o = win_q;
  assign ctl_o = ctl_q;

endmodule

// File: rtl/dmawin_match.sv
module dmawin_match
  import dmawin_pkg::*;
#(
  parameter int NWIN    = 4,
  parameter int DAC_BIT = 43
) (
  input  logic [XW-1:0]        addr,
  input  win_regs_t [NWIN-1:0] win,
  input  logic [XW-1:0]        ctl,
  output xl_kind_e             kind,
  output logic [XW-1:0]        direct_addr,
  output logic [XW-1:0]        pte_addr
);

  localparam int LASTW = NWIN - 1;

  logic [NWIN-1:0] hit;
  logic [NWIN-1:0] is_sg;
  logic [XW-1:0]   dmap [NWIN];
  logic [XW-1:0]   pidx [NWIN];

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    logic [XW-1:0] ext;
    assign ext      = win[i].mask | LOW_SPAN;
    assign hit[i]   = win[i].base[0] && ((addr & ~ext) == (win[i].base & BASE_FIELD));
    assign is_sg[i] = win[i].base[1];
    assign dmap[i]  = (win[i].tba & ~ext) | (addr & ext);
    assign pidx[i]  = (win[i].tba & ~(win[i].mask >> PTE_SHIFT))
                    | ((addr & (win[i].mask | SG_IDX_BITS)) >> PTE_SHIFT);
  end

  logic sac, hole, big_rng, dac_rng, dac_on;

  assign sac     = (addr[XW-1:32] == '0);
  assign hole    = ctl[HOLE_EN_BIT] && (addr[XW-1:19] == 45'h1);
  assign big_rng = (addr[XW-1:40] == 24'h1);
  assign dac_rng = (addr[XW-1:43] == 21'h1);
  assign dac_on  = win[LASTW].base[DAC_BIT];

  logic unused_ctl;
  assign unused_ctl = ^{ctl[XW-1:BIGWIN_EN_BIT+1], ctl[HOLE_EN_BIT-1:0]};

  always_comb begin
    logic found;
    found       = 1'b0;
    kind        = XL_FAIL;
    direct_addr = '0;
    pte_addr    = '0;
    if (sac) begin
      if (!hole) begin
        for (int i = 0; i < NWIN; i++) begin
          if (!found && hit[i] && ((i != LASTW) || !dac_on)) begin
            found = 1'b1;
            if (is_sg[i]) begin
              kind     = XL_SG;
              pte_addr = pidx[i];
            end else begin
              kind        = XL_DIRECT;
              direct_addr = dmap[i];
            end
          end
        end
      end
    end else if (big_rng && ctl[BIGWIN_EN_BIT]) begin
      kind        = XL_DIRECT;
      direct_addr = addr & BIG_WIN_MASK;
    end else if (dac_rng && win[LASTW].base[0] && dac_on) begin
      kind     = XL_SG;
      pte_addr = (win[LASTW].tba & DAC_TBA_KEEP)
               | ((addr & DAC_IDX_BITS) >> PTE_SHIFT);
    end
  end

endmodule

// File: rtl/dmawin_ctrl.sv
module dmawin_ctrl
  import dmawin_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [XW-1:0] req_addr,
  input  xl_kind_e      kind,
  input  logic [XW-1:0] direct_addr,
  input  logic [XW-1:0] pte_addr,
  input  logic          mem_rd_ready,
  input  logic          mem_rsp_valid,
  input  logic [XW-1:0] mem_rsp_data,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [XW-1:0] rsp_addr,
  output logic          mem_rd_valid,
  output logic [XW-1:0] mem_rd_addr
);

  xl_state_e              st_q, st_d;
  logic [XW-1:0]          res_q, res_d;
  logic                   ok_q, ok_d;
  logic [XW-1:0]          pa_q, pa_d;
  logic [PAGE_BITS-1:0]   off_q, off_d;
  logic                   res_en, pa_en;

  logic unused_bits;
  assign unused_bits = ^{req_addr[XW-1:PAGE_BITS], mem_rsp_data[XW-1:22]};

  always_comb begin
    st_d   = st_q;
    res_d  = res_q;
    ok_d   = ok_q;
    pa_d   = pa_q;
    off_d  = off_q;
    res_en = 1'b0;
    pa_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          unique case (kind)
            XL_DIRECT: begin
              ok_d = 1'b1; res_d = direct_addr; res_en = 1'b1; st_d = ST_RESP;
            end
            XL_SG: begin
              pa_d = pte_addr; off_d = req_addr[PAGE_BITS-1:0]; pa_en = 1'b1;
              st_d = ST_FETCH;
            end
            default: begin
              ok_d = 1'b0; res_d = '0; res_en = 1'b1; st_d = ST_RESP;
            end
          endcase
        end
      end
      ST_FETCH: begin
        if (mem_rd_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          res_en = 1'b1;
          st_d   = ST_RESP;
          if (mem_rsp_data[0]) begin
            ok_d  = 1'b1;
            res_d = ((mem_rsp_data & PTE_PFN_BITS) << PFN_SHIFT) | XW'(off_q);
          end else begin
            ok_d  = 1'b0;
            res_d = '0;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ok_q  <= 1'b0;
    end else if (res_en) begin
      res_q <= res_d;
      ok_q  <= ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      off_q <= '0;
    end else if (pa_en) begin
      pa_q  <= pa_d;
      off_q <= off_d;
    end
  end

  assign req_ready    = (st_q == ST_IDLE);
  assign rsp_valid    = (st_q == ST_RESP);
  assign rsp_ok       = ok_q;
  assign rsp_addr     = res_q;
  assign mem_rd_valid = (st_q == ST_FETCH);
  assign mem_rd_addr  = pa_q;

endmodule

// File: rtl/dmawin_xlate.sv
module dmawin_xlate
  import dmawin_pkg::*;
#(
  parameter int NWIN    = 4,
  parameter int DAC_BIT = 43,
  parameter int CAW     = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           csr_we,
  input  logic [CAW-1:0] csr_addr,
  input  logic [63:0]    csr_wdata,
  output logic [63:0]    csr_rdata,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [63:0]    req_addr,
  output logic           rsp_valid,
  output logic           rsp_ok,
  output logic [63:0]    rsp_addr,
  output logic           mem_rd_valid,
  input  logic           mem_rd_ready,
  output logic [63:0]    mem_rd_addr,
  input  logic           mem_rsp_valid,
  input  logic [63:0]    mem_rsp_data
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  win_regs_t [NWIN-1:0] win;
  logic [XW-1:0]        ctl_q;
  xl_kind_e             kind;
  logic [XW-1:0]        direct_addr, pte_addr;

  dmawin_regs #(.NWIN(NWIN), .DAC_BIT(DAC_BIT), .CAW(CAW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .win_o     (win),
    .ctl_o     (ctl_q)
  );

  dmawin_match #(.NWIN(NWIN), .DAC_BIT(DAC_BIT)) match_i (
    .addr        (req_addr),
    .win         (win),
    .ctl         (ctl_q),
    .kind        (kind),
    .direct_addr (direct_addr),
    .pte_addr    (pte_addr)
  );

  dmawin_ctrl ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .kind          (kind),
    .direct_addr   (direct_addr),
    .pte_addr      (pte_addr),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ok        (rsp_ok),
    .rsp_addr      (rsp_addr),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_addr   (mem_rd_addr)
  );

endmodule

// File: rtl/dmawin_xlate_chk.sv
module dmawin_xlate_chk #(
  parameter int CAW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CAW-1:0] csr_addr,
  input logic [63:0]    csr_rdata,
  input logic           req_valid,
  input logic           req_ready,
  input logic [63:0]    req_addr,
  input logic           rsp_valid,
  input logic           rsp_ok,
  input logic [63:0]    rsp_addr,
  input logic           mem_rd_valid,
  input logic           mem_rd_ready,
  input logic [63:0]    mem_rd_addr,
  input logic [63:0]    ctl_q
);

  // R12: no new request is taken while a response is on the port
  a_r12_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R12: failed responses carry a zero address
  a_r12_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_addr == 64'd0));

  // R4: the response strobe lasts a single cycle
  a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5: a stalled page-entry read keeps its request and address
  a_r5_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R2: the last window's base always reads with its table bit set
  a_r2_win3_sg_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == CAW'(12'h0C0)) |-> csr_rdata[1]);

  // R9: an accepted address inside the hole fails on the next cycle
  a_r9_hole_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ctl_q[5] && (req_addr[63:19] == 45'h1))
      |=> (rsp_valid && !rsp_ok));

  // R10: the large direct window answers on the next cycle with the low bits
  a_r10_big_window: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ctl_q[6] && (req_addr[63:40] == 24'h1))
      |=> (rsp_valid && rsp_ok && (rsp_addr == ($past(req_addr) & 64'h7_FFFF_FFFF))));

endmodule

bind dmawin_xlate dmawin_xlate_chk #(.CAW(CAW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .csr_addr     (csr_addr),
  .csr_rdata    (csr_rdata),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_ok       (rsp_ok),
  .rsp_addr     (rsp_addr),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .ctl_q        (ctl_q)
);

// File: tb/dmawin_xlate_tb_top.sv
`timescale 1ns/1ps
module dmawin_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_we;
  logic [11:0] csr_addr;
  logic [63:0] csr_wdata;
  logic [63:0] csr_rdata;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_addr;
  logic        rsp_valid;
  logic        rsp_ok;
  logic [63:0] rsp_addr;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;

  int unsigned nchk = 0;
  int unsigned nerr = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dmawin_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [11:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    csr_addr = a;
    #1;
    chk(tag, csr_rdata, exp);
  endtask

  // fetch-free path: result due one cycle after acceptance, for one cycle
  task automatic xl_direct(input logic [63:0] a, input logic eok, input logic [63:0] ea,
                           input string tag);
    @(negedge clk);
    chk({tag, " ready"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " ok"}, 64'(rsp_ok), 64'(eok));
    chk({tag, " addr"}, rsp_addr, ea);
    chk({tag, " R12 busy"}, 64'(req_ready), 64'd0);
    @(negedge clk);
    chk({tag, " pulse end"}, 64'(rsp_valid), 64'd0);
    chk({tag, " idle"}, 64'(req_ready), 64'd1);
  endtask

  // table path: read request one cycle after acceptance, result one cycle after data
  task automatic xl_sg(input logic [63:0] a, input logic [63:0] epa, input logic [63:0] pte,
                       input logic eok, input logic [63:0] ea, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rd valid"}, 64'(mem_rd_valid), 64'd1);
    chk({tag, " pte addr"}, mem_rd_addr, epa);
    chk({tag, " R12 busy"}, 64'(req_ready), 64'd0);
    @(negedge clk);
    chk({tag, " rd held"}, 64'(mem_rd_valid), 64'd1);
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    chk({tag, " rd done"}, 64'(mem_rd_valid), 64'd0);
    mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " ok"}, 64'(rsp_ok), 64'(eok));
    chk({tag, " addr"}, rsp_addr, ea);
    @(negedge clk);
    chk({tag, " pulse end"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 mem_rd_valid", 64'(mem_rd_valid), 64'd0);
    csr_rd(12'h000, 64'h0, "R1 base0");
    csr_rd(12'h140, 64'h0, "R1 mask1");
    csr_rd(12'h280, 64'h0, "R1 tba2");
    csr_rd(12'h0C0, 64'h2, "R1 base3");
    csr_rd(12'h300, 64'h0, "R1 ctl");
  endtask

  task automatic t_csr_masks;
    csr_wr(12'h040, '1);
    csr_rd(12'h040, 64'hFFF0_0003, "R2 base1 keep");
    csr_wr(12'h100, '1);
    csr_rd(12'h100, 64'hFFF0_0000, "R2 mask0 keep");
    csr_wr(12'h2C0, '1);
    csr_rd(12'h2C0, 64'h7_FFFF_FC00, "R2 tba3 keep");
    csr_wr(12'h0C0, '1);
    csr_rd(12'h0C0, 64'h800_FFF0_0003, "R2 base3 keep");
    csr_wr(12'h0C0, 64'h0);
    csr_rd(12'h0C0, 64'h2, "R2 base3 forced");
    csr_wr(12'h040, 64'h0);
    csr_wr(12'h100, 64'h0);
    csr_wr(12'h2C0, 64'h0);
  endtask

  task automatic t_ctl_mask;
    csr_wr(12'h300, '1);
    csr_rd(12'h300, 64'h1C_FF0F_C7FF, "R3 ctl keep");
    csr_wr(12'h300, 64'h0);
    csr_rd(12'h300, 64'h0, "R3 ctl clear");
  endtask

  task automatic t_direct;
    csr_wr(12'h040, 64'h4000_0001);
    csr_wr(12'h140, 64'h0FF0_0000);
    csr_wr(12'h240, 64'h2_0000_0000);
    xl_direct(64'h4123_4567, 1'b1, 64'h2_0123_4567, "R4 direct win1");
    xl_direct(64'h5000_0000, 1'b0, 64'h0, "R12 no match");
  endtask

  task automatic t_priority;
    csr_wr(12'h000, 64'h4000_0001);
    csr_wr(12'h100, 64'h0);
    csr_wr(12'h200, 64'h1_0000_0000);
    xl_direct(64'h4001_2345, 1'b1, 64'h1_0001_2345, "R7 win0 first");
    xl_direct(64'h4123_4567, 1'b1, 64'h2_0123_4567, "R7 falls to win1");
  endtask

  task automatic t_sg;
    csr_wr(12'h080, 64'h8000_0003);
    csr_wr(12'h180, 64'h0010_0000);
    csr_wr(12'h280, 64'h1_2340_0000);
    xl_sg(64'h8015_6789, 64'h1_2340_0558, 64'h12_3457, 1'b1, 64'h1_2345_6789, "R5 sg win2");
  endtask

  task automatic t_sg_invalid;
    xl_sg(64'h8015_6789, 64'h1_2340_0558, 64'h12_3456, 1'b0, 64'h0, "R6 pte invalid");
  endtask

  task automatic t_win3_sac;
    csr_wr(12'h0C0, 64'hC000_0001);
    csr_wr(12'h1C0, 64'h0);
    csr_wr(12'h2C0, 64'h5_0000_0000);
    xl_sg(64'hC000_4000, 64'h5_0000_0010, 64'h3, 1'b1, 64'h2000, "R8 win3 single");
    csr_wr(12'h0C0, 64'h800_C000_0001);
    xl_direct(64'hC000_4000, 1'b0, 64'h0, "R8 win3 blocked by dual bit");
  endtask

  task automatic t_dac_sg;
    csr_rd(12'h0C0, 64'h800_C000_0003, "R2 base3 dual bit");
    xl_sg(64'h800_1234_6000, 64'h5_0004_8D18, 64'hA_BCDF, 1'b1, 64'hABCD_E000, "R11 dual sg");
    csr_wr(12'h0C0, 64'h800_C000_0000);
    xl_direct(64'h800_1234_6000, 1'b0, 64'h0, "R11 win3 disabled");
    csr_wr(12'h0C0, 64'h0);
  endtask

  task automatic t_hole;
    csr_wr(12'h000, 64'h0000_0001);
    csr_wr(12'h100, 64'h0);
    csr_wr(12'h200, 64'h3_0000_0000);
    xl_direct(64'h0008_1000, 1'b1, 64'h3_0008_1000, "R9 hole off");
    csr_wr(12'h300, 64'h20);
    xl_direct(64'h0008_1000, 1'b0, 64'h0, "R9 hole on");
    xl_direct(64'h0007_F000, 1'b1, 64'h3_0007_F000, "R9 below hole");
    csr_wr(12'h300, 64'h0);
  endtask

  task automatic t_big_window;
    xl_direct(64'h1AB_CDEF_0123, 1'b0, 64'h0, "R10 big window off");
    csr_wr(12'h300, 64'h40);
    xl_direct(64'h1AB_CDEF_0123, 1'b1, 64'h3_CDEF_0123, "R10 big window on");
    csr_wr(12'h300, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_csr_masks();
    t_ctl_mask();
    t_direct();
    t_priority();
    t_sg();
    t_sg_invalid();
    t_win3_sac();
    t_dac_sg();
    t_hole();
    t_big_window();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule